// File: doc/BRIEF.md
# Energy-Detect Power-Down Link Pulse Controller

This block handles normal link pulses (NLPs) while an Ethernet PHY rests in energy-detect power-down. A 16-bit configuration register, written and read through a plain register port, chooses whether the PHY sends periodic NLPs, how often it sends them, and which rule turns received NLPs into a wake request. Time is measured in whole ticks of a 1 ms timebase input.

Outgoing pulses are requested through a one-cycle strobe at one of four intervals. Wake can follow either of two rules. Under the first rule, any single received NLP wakes the PHY. Under the second rule, a wake needs a first NLP and then a second one within a selectable maximum gap. A separate stored bit asks the crossover logic for a fixed extension, and the block supplies that extension's length in milliseconds.

Top module: `edpd_nlp_ctrl`

## Requirements
- R1: Out of reset the register reads 0x0000. A write stores bit 15 (transmit enable), bits 14:13 (transmit interval select), bit 12 (single-pulse wake enable), bits 11:10 (wake gap select) and bit 0 (crossover extension enable). Bits 9:1 always read zero, so a write of 0xFFFF reads back as 0xFC01.
- R2: While `pwr_down` is 0, `nlp_tx` and `wake_req` stay low whatever the configuration and `nlp_rx` are.
- R3: With power-down active and transmit enabled, `nlp_tx` pulses on the Nth timebase tick after entry and then every N ticks. The interval select maps code 0 to N=1000, code 1 to N=768, code 2 to N=512 and code 3 to N=256. The strobe is high in the cycle after the clock edge that samples that tick. With transmit disabled, no strobe is issued.
- R4: When the transmit enable goes from 0 to 1, the interval count restarts from zero.
- R5: With single-pulse wake enabled during power-down, one received NLP raises `wake_req` in the cycle after it is sampled.
- R6: With single-pulse wake disabled, a first NLP arms a gap window. A second NLP raises `wake_req` if it arrives no later than the cycle carrying the Mth tick after arming. The gap select maps code 0 to M=64, code 1 to M=256, code 2 to M=512 and code 3 to M=1000. A lone NLP never wakes.
- R7: When the Mth tick passes without a second NLP, the window closes. The next NLP then arms a new window and does not wake.
- R8: Once raised, `wake_req` stays high until `pwr_down` falls, and it is low in the cycle after that. Leaving power-down discards an armed window.
- R9: `xover_ext_en` follows register bit 0, and `xover_ext_ms` carries the constant 1984.
- R10: A write that changes the transmit interval select during counting does not reset the count. The new limit applies at the next tick.
- R11: `nlp_tx` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 16 | Register write data |
| cfg_rdata | output | 16 | Register read data |
| pwr_down | input | 1 | PHY is in energy-detect power-down |
| tick_ms | input | 1 | One-cycle 1 ms timebase tick |
| nlp_rx | input | 1 | One-cycle strobe per received NLP |
| nlp_tx | output | 1 | One-cycle request to send one NLP |
| wake_req | output | 1 | Sticky wake request |
| xover_ext_en | output | 1 | Crossover extension enable |
| xover_ext_ms | output | 11 | Crossover extension length in ms (1984) |

## Verification
The bound checker watches, on every cycle, the rules that need no arithmetic on intervals. These are: outputs stay quiet outside power-down, the transmit strobe is a lone pulse that follows a tick, a wake only starts after a received NLP, the wake request holds during power-down, and the register keeps exactly the writable bits. The tick counts themselves can only be shown by the bench scenarios. These include the exact tick of each transmit strobe for all four interval codes, the restart on re-enable, and the count that survives an interval change. For every gap code, the bench also checks the wake on a second pulse landing exactly on the Mth tick and the failure to wake one cycle after it.

// File: rtl/edpd_nlp_ctrl.sv
module edpd_nlp_ctrl #(
  parameter int TX_N0 = 1000,
  parameter int TX_N1 = 768,
  parameter int TX_N2 = 512,
  parameter int TX_N3 = 256,
  parameter int GAP_M0 = 64,
  parameter int GAP_M1 = 256,
  parameter int GAP_M2 = 512,
  parameter int GAP_M3 = 1000,
  parameter int XOVER_MS = 1984,
  parameter int XW = $clog2(XOVER_MS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [15:0]   cfg_wdata,
  output logic [15:0]   cfg_rdata,
  input  logic          pwr_down,
  input  logic          tick_ms,
  input  logic          nlp_rx,
  output logic          nlp_tx,
  output logic          wake_req,
  output logic          xover_ext_en,
  output logic [XW-1:0] xover_ext_ms
);

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  localparam int TMAX = max4(max4(TX_N0, TX_N1, TX_N2, TX_N3), GAP_M0, GAP_M1,
                             max4(GAP_M0, GAP_M1, GAP_M2, GAP_M3));
  localparam int CW = $clog2(TMAX + 1);

  logic          tx_en, rx_single, xext;
  logic [1:0]    tx_sel, gap_sel;
  logic [CW-1:0] tx_cnt, gap_cnt, tx_lim, gap_lim;
  logic          armed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_en     <= 1'b0;
      tx_sel    <= 2'd0;
      rx_single <= 1'b0;
      gap_sel   <= 2'd0;
      xext      <= 1'b0;
    end else if (cfg_we) begin
      tx_en     <= cfg_wdata[15];
      tx_sel    <= cfg_wdata[14:13];
      rx_single <= cfg_wdata[12];
      gap_sel   <= cfg_wdata[11:10];
      xext      <= cfg_wdata[0];
    end
  end

  assign cfg_rdata    = {tx_en, tx_sel, rx_single, gap_sel, 9'd0, xext};
  assign xover_ext_en = xext;
  assign xover_ext_ms = XW'(XOVER_MS);

  always_comb begin
    case (tx_sel)
      2'd0:    tx_lim = CW'(TX_N0);
      2'd1:    tx_lim = CW'(TX_N1);
      2'd2:    tx_lim = CW'(TX_N2);
      default: tx_lim = CW'(TX_N3);
    endcase
    case (gap_sel)
      2'd0:    gap_lim = CW'(GAP_M0);
      2'd1:    gap_lim = CW'(GAP_M1);
      2'd2:    gap_lim = CW'(GAP_M2);
      default: gap_lim = CW'(GAP_M3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_down || !tx_en) begin
      tx_cnt <= '0;
      nlp_tx <= 1'b0;
    end else begin
      nlp_tx <= 1'b0;
      if (tick_ms) begin
        if (tx_cnt + CW'(1) >= tx_lim) begin
          tx_cnt <= '0;
          nlp_tx <= 1'b1;
        end else begin
          tx_cnt <= tx_cnt + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !pwr_down) begin
      wake_req <= 1'b0;
      armed    <= 1'b0;
      gap_cnt  <= '0;
    end else if (!wake_req) begin
      if (nlp_rx && (rx_single || armed)) begin
        wake_req <= 1'b1;
        armed    <= 1'b0;
      end else if (nlp_rx) begin
        armed   <= 1'b1;
        gap_cnt <= '0;
      end else if (armed && tick_ms) begin
        if (gap_cnt + CW'(1) >= gap_lim) begin
          armed   <= 1'b0;
          gap_cnt <= '0;
        end else begin
          gap_cnt <= gap_cnt + CW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/edpd_nlp_ctrl_chk.sv
module edpd_nlp_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_we,
  input logic [15:0] cfg_wdata,
  input logic [15:0] cfg_rdata,
  input logic        pwr_down,
  input logic        tick_ms,
  input logic        nlp_rx,
  input logic        nlp_tx,
  input logic        wake_req
);

  // R1
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> cfg_rdata == ($past(cfg_wdata) & 16'hFC01));

  // R2
  quiet_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_down |=> !nlp_tx);

  // R2
  quiet_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_down |=> !wake_req);

  // R3
  tx_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nlp_tx |-> $past(tick_ms));

  // R5
  wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_req) |-> $past(nlp_rx));

  // R8
  wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_req && pwr_down) |=> wake_req);

  // R11
  tx_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nlp_tx |=> !nlp_tx);

endmodule

bind edpd_nlp_ctrl edpd_nlp_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .pwr_down(pwr_down), .tick_ms(tick_ms),
  .nlp_rx(nlp_rx), .nlp_tx(nlp_tx), .wake_req(wake_req)
);

// File: tb/edpd_nlp_ctrl_tb.sv
module edpd_nlp_ctrl_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;
  logic        pwr_down = 0;
  logic        nlp_rx = 0;
  logic        nlp_tx, wake_req, xover_ext_en;
  logic [10:0] xover_ext_ms;
  logic [1:0]  ph;
  logic        tick_ms;
  int tick_no, scnt, s_prev, s_last, dbl, cyc;
  int total = 0, fails = 0;
  logic prev_tx;

  always #2.5 clk = ~clk;

  edpd_nlp_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .pwr_down(pwr_down), .tick_ms(tick_ms),
    .nlp_rx(nlp_rx), .nlp_tx(nlp_tx), .wake_req(wake_req),
    .xover_ext_en(xover_ext_en), .xover_ext_ms(xover_ext_ms)
  );

  assign tick_ms = (ph == 2'd3);

  always @(posedge clk) begin
    if (!rst_n) begin
      ph <= 0; tick_no <= 0;
    end else begin
      ph <= ph + 1'b1;
      tick_no <= tick_no + (tick_ms ? 1 : 0);
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      scnt = 0; s_prev = -1; s_last = -1; dbl = 0; prev_tx = 0;
    end else begin
      if (nlp_tx) begin
        scnt++; s_prev = s_last; s_last = tick_no;
        if (prev_tx) dbl++;
      end
      prev_tx = nlp_tx;
    end
  end

  function automatic int tx_n(int c);
    return (c == 0) ? 1000 : (c == 1) ? 768 : (c == 2) ? 512 : 256;
  endfunction
  function automatic int gap_m(int c);
    return (c == 0) ? 64 : (c == 1) ? 256 : (c == 2) ? 512 : 1000;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] v);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_now();
    nlp_rx = 1;
    @(negedge clk);
    nlp_rx = 0;
  endtask

  task automatic wait_tick(input int target);
    while (tick_no < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic arm(output int ta);
    while (tick_ms) @(negedge clk);
    pulse_now();
    ta = tick_no;
  endtask

  task automatic pd_cycle();
    pwr_down = 0;
    repeat (2) @(negedge clk);
    pwr_down = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int t0, base, ta;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset rdata", cfg_rdata, 0);
    chk("R2 reset nlp_tx", nlp_tx, 0);
    chk("R2 reset wake", wake_req, 0);
    chk("R9 reset ext", xover_ext_en, 0);
    chk("R9 ext ms", xover_ext_ms, 1984);

    wr(16'hFFFF);
    chk("R1 all ones", cfg_rdata, 16'hFC01);
    chk("R9 ext on", xover_ext_en, 1);
    wr(16'h0000);
    chk("R1 cleared", cfg_rdata, 0);
    chk("R9 ext off", xover_ext_en, 0);
    wr(16'h8C00);
    chk("R1 mixed", cfg_rdata, 16'h8C00);

    // R2: nothing outside power-down
    wr(16'hF000);
    base = scnt;
    for (int i = 0; i < 5; i++) begin pulse_now(); @(negedge clk); end
    wait_tick(tick_no + 300);
    chk("R2 no tx", scnt - base, 0);
    chk("R2 no wake", wake_req, 0);

    // R3: interval sweep
    for (int c = 0; c < 4; c++) begin
      pwr_down = 0;
      wr(16'h8000 | 16'(c << 13));
      @(negedge clk);
      pwr_down = 1; t0 = tick_no; base = scnt;
      wait_tick(t0 + 2 * tx_n(c));
      @(negedge clk);
      chk("R3 strobe count", scnt - base, 2);
      chk("R3 first strobe tick", s_prev - t0, tx_n(c));
      chk("R3 second strobe tick", s_last - t0, 2 * tx_n(c));
    end
    pwr_down = 0;
    wr(16'h6000);
    @(negedge clk);
    pwr_down = 1; base = scnt;
    wait_tick(tick_no + 1100);
    chk("R3 disabled", scnt - base, 0);

    // R4: restart on enable
    wr(16'hE000);
    wait_tick(tick_no + 100);
    wr(16'h6000);
    wait_tick(tick_no + 10);
    wr(16'hE000);
    t0 = tick_no; base = scnt;
    wait_tick(t0 + 256);
    @(negedge clk);
    chk("R4 restart count", scnt - base, 1);
    chk("R4 restart tick", s_last - t0, 256);

    // R10: interval change keeps count
    pwr_down = 0;
    wr(16'h8000);
    @(negedge clk);
    pwr_down = 1; t0 = tick_no; base = scnt;
    wait_tick(t0 + 100);
    wr(16'hC000);
    wait_tick(t0 + 512);
    @(negedge clk);
    chk("R10 count", scnt - base, 1);
    chk("R10 tick", s_last - t0, 512);
    chk("R11 no adjacent strobes", dbl, 0);

    // R5 / R8: single-pulse wake
    pwr_down = 0;
    wr(16'h1000);
    @(negedge clk);
    pwr_down = 1;
    @(negedge clk);
    chk("R5 before pulse", wake_req, 0);
    pulse_now();
    chk("R5 wake", wake_req, 1);
    repeat (20) @(negedge clk);
    chk("R8 held", wake_req, 1);
    pwr_down = 0;
    @(negedge clk);
    chk("R8 cleared", wake_req, 0);

    // R6 / R7: gap sweep
    for (int g = 0; g < 4; g++) begin
      wr(16'(g << 10));
      pd_cycle();
      arm(ta);
      repeat (3) @(negedge clk);
      chk("R6 lone pulse", wake_req, 0);
      while (!(tick_ms && tick_no == ta + gap_m(g) - 1)) @(negedge clk);
      pulse_now();
      chk("R6 second on last tick", wake_req, 1);

      pd_cycle();
      arm(ta);
      while (!(tick_no == ta + gap_m(g) && !tick_ms)) @(negedge clk);
      pulse_now();
      chk("R7 late pulse", wake_req, 0);
      repeat (2) @(negedge clk);
      pulse_now();
      chk("R7 rearmed wake", wake_req, 1);
    end

    // R8: leaving power-down drops armed window
    wr(16'h0000);
    pd_cycle();
    arm(ta);
    pd_cycle();
    @(negedge clk);
    pulse_now();
    repeat (3) @(negedge clk);
    chk("R8 armed dropped", wake_req, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule